// File: doc/BRIEF.md
# Interrupt Steering and Sticky Status Unit

This unit gathers interrupt requests from nine on-board sources and steers each one onto one of eleven legacy IRQ lines. The sources are three timer channels, one auxiliary GPIO group, one watchdog, two UARTs and two expansion-bus interrupts. The timer, GPIO and watchdog events are caught in sticky status bits that software clears by writing a one. The UART and expansion requests are not latched: their pending state belongs to the device that raises them, so they pass through as live levels.

Each source has a 4-bit routing code that picks its IRQ line, or leaves it unassigned. Several sources may share one line. Each line has its own enable. The unit drives two vectors to a downstream serial interrupt frame generator. One is a per-line level, equal to the OR of the pending sources routed to that line, forced low while the line is disabled. The other is a slot-active mask that equals the enables.

Software reaches the unit through a byte-wide port with a strobed write and a combinational read. Reads have no side effects.

Top module: `intr_router`

Line index k of `irq_level` and `slot_active` carries these IRQ numbers:

| Index | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 | 8 | 9 | 10 |
|-------|---|---|---|---|---|---|---|---|---|---|----|
| IRQ   | 3 | 4 | 5 | 6 | 7 | 9 | 10 | 11 | 12 | 14 | 15 |

## Requirements
- R1: A routing code c from 1 to 8 steers its source to line index c-1, which is IRQ 3, 4, 5, 6, 7, 9, 10 or 11. Code 0 and codes 9 to 15 leave the source unassigned, so it drives no line. No source can reach indices 8 to 10.
- R2: The enables are all zero after reset. Writing address 0x2 sets the enables of indices 0 to 7 from data bits 0 to 7. Writing address 0x3 sets indices 8 to 10 from data bits 0 to 2. Both bytes read back, `slot_active` equals the enable vector, and the enables change only on a write to their own address.
- R3: Address 0x0 holds the sticky status: bits 0 to 2 are timer channels 0 to 2, bit 3 is the GPIO group and bit 4 is the watchdog. A bit sets after any clock edge at which its input is high. It then holds until a write to 0x0 with a one in that bit position. Zero bits in the write leave status unchanged, and bits 7 to 5 read as 0.
- R4: If a source input is high in the same cycle as a write-one-to-clear of its status bit, the bit remains set.
- R5: The UART and expansion inputs are never latched. Each one reaches its routed line in the same cycle it changes. Address 0x1 reads them live: bit 0 is UART 0, bit 1 is UART 1, bit 2 is expansion 0 and bit 3 is expansion 1.
- R6: `irq_level[k]` is high only when line k is enabled and at least one source routed to it is pending. A disabled line is low, and its slot is inactive, even while its sources stay pending.
- R7: Sources routed to the same line are ORed together. Clearing one of them leaves the line high while another is still pending.
- R8: The routing codes sit in addresses 0x4 to 0x8, two per byte, in this source order: timer 0, timer 1, timer 2, GPIO, watchdog, UART 0, UART 1, expansion 0, expansion 1. Source 2j is in the low nibble of address 0x4+j and source 2j+1 is in the high nibble. The codes read back as written. The unused high nibble of 0x8, and any address above 0x8, reads as 0.
- R9: Reset clears all sticky status bits and all routing codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| tmr_evt | input | 3 | Timer channel events, active high |
| gpio_evt | input | 1 | Auxiliary GPIO group event |
| wdt_evt | input | 1 | Watchdog event |
| uart_irq | input | 2 | UART interrupt levels |
| exp_irq | input | 2 | Expansion-bus interrupt levels |
| irq_level | output | 11 | Per-line interrupt level, high-true |
| slot_active | output | 11 | Per-line slot-active mask |

## Verification
The bench builds the unit with its default parameters: nine sources, eleven lines, 4-bit routing codes and 8 routable lines. Every code boundary therefore falls inside the 4-bit field. That covers the last routable code (8), the first out-of-range code (9), and the three lines that can be enabled but never receive a source. With these values the bench can also place two sticky sources on one line and check that a set and a clear landing on the same edge keep the bit set.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int N_TMR      = 3;
    localparam int N_STICKY   = N_TMR + 2;
    localparam int N_LIVE     = 4;
    localparam int N_SRC      = N_STICKY + N_LIVE;
    localparam int N_LINES    = 11;
    localparam int N_ROUTABLE = 8;
    localparam int ROUTE_W    = 4;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;

    localparam logic [ADDR_W-1:0] A_STAT   = 4'h0;
    localparam logic [ADDR_W-1:0] A_LIVE   = 4'h1;
    localparam logic [ADDR_W-1:0] A_EN_LO  = 4'h2;
    localparam logic [ADDR_W-1:0] A_EN_HI  = 4'h3;
    localparam logic [ADDR_W-1:0] A_ROUTE0 = 4'h4;

    // Turns a routing code into a one-hot line mask; codes outside 1..N_ROUTABLE give zero.
    function automatic logic [N_LINES-1:0] route_to_mask(input logic [ROUTE_W-1:0] code);
        logic [N_LINES-1:0] m;
        m = '0;
        for (int k = 0; k < N_ROUTABLE; k++) begin
            if (int'(code) == k + 1) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sticky_status.sv
module sticky_status
    import irqs_pkg::*;
#(
    parameter int WIDTH = N_STICKY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (evt[b])
                    bit_q <= 1'b1;
                else if (clr_stb && clr_mask[b])
                    bit_q <= 1'b0;
            end
            assign status[b] = bit_q;

            // R3: a set bit stays set unless a one is written to it
            p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (bit_q && !(clr_stb && clr_mask[b])) |=> bit_q);

            // R4: an event wins over a same-cycle clear
            p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[b] && clr_stb && clr_mask[b]) |=> bit_q);
        end
    endgenerate

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irqs_pkg::*;
#(
    parameter int NSRC    = N_SRC,
    parameter int NLINE   = N_LINES,
    parameter int NROUTE  = N_ROUTABLE,
    parameter int NSTICKY = N_STICKY,
    parameter int NLIVE   = N_LIVE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [NSTICKY-1:0]       status,
    input  logic [NLIVE-1:0]         live,
    output logic                     clr_stb,
    output logic [NSTICKY-1:0]       clr_mask,
    output logic [NLINE-1:0]         en,
    output logic [NSRC*ROUTE_W-1:0]  route_flat
);

    localparam int NHI = NLINE - NROUTE;

    logic [NLINE-1:0]   en_q;
    logic [ROUTE_W-1:0] route_q [NSRC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && addr == A_EN_LO) begin
            en_q[NROUTE-1:0] <= wr_data[NROUTE-1:0];
        end else if (wr_en && addr == A_EN_HI) begin
            en_q[NLINE-1:NROUTE] <= wr_data[NHI-1:0];
        end
    end

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_route
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_ROUTE0) + s / 2);
            localparam int                LSB     = (s % 2) * ROUTE_W;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    route_q[s] <= '0;
                else if (wr_en && addr == MY_ADDR)
                    route_q[s] <= wr_data[LSB +: ROUTE_W];
            end
            assign route_flat[s*ROUTE_W +: ROUTE_W] = route_q[s];
        end
    endgenerate

    assign en       = en_q;
    assign clr_stb  = wr_en && (addr == A_STAT);
    assign clr_mask = wr_data[NSTICKY-1:0];

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_STAT:  rd_data[NSTICKY-1:0] = status;
            A_LIVE:  rd_data[NLIVE-1:0]   = live;
            A_EN_LO: rd_data[NROUTE-1:0]  = en_q[NROUTE-1:0];
            A_EN_HI: rd_data[NHI-1:0]     = en_q[NLINE-1:NROUTE];
            default: begin
                for (int i = 0; i < NSRC; i++) begin
                    if (int'(addr) == int'(A_ROUTE0) + i / 2)
                        rd_data[(i % 2) * ROUTE_W +: ROUTE_W] = route_q[i];
                end
            end
        endcase
    end

    // R2: enables move only on a write strobe
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/route_matrix.sv
module route_matrix
    import irqs_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int NLINE = N_LINES
) (
    input  logic [NSRC-1:0]          pending,
    input  logic [NSRC*ROUTE_W-1:0]  route_flat,
    input  logic [NLINE-1:0]         en,
    output logic [NLINE-1:0]         level
);

    logic [NLINE-1:0] hit [NSRC];

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_src
            assign hit[s] = pending[s] ? route_to_mask(route_flat[s*ROUTE_W +: ROUTE_W]) : '0;
        end
    endgenerate

    always_comb begin
        logic [NLINE-1:0] acc;
        acc = '0;
        for (int i = 0; i < NSRC; i++) acc = acc | hit[i];
        level = acc & en;
    end

endmodule

// File: rtl/intr_router.sv
module intr_router
    import irqs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [N_TMR-1:0]     tmr_evt,
    input  logic                 gpio_evt,
    input  logic                 wdt_evt,
    input  logic [1:0]           uart_irq,
    input  logic [1:0]           exp_irq,
    output logic [N_LINES-1:0]   irq_level,
    output logic [N_LINES-1:0]   slot_active
);

    logic [N_STICKY-1:0]      evt_vec;
    logic [N_STICKY-1:0]      status;
    logic [N_LIVE-1:0]        live;
    logic                     clr_stb;
    logic [N_STICKY-1:0]      clr_mask;
    logic [N_LINES-1:0]       en;
    logic [N_SRC*ROUTE_W-1:0] route_flat;
    logic [N_SRC-1:0]         pending;

    assign evt_vec = {wdt_evt, gpio_evt, tmr_evt};
    assign live    = {exp_irq, uart_irq};
    assign pending = {live, status};

    sticky_status #(.WIDTH(N_STICKY)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_vec),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .status   (status)
    );

    irq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .status     (status),
        .live       (live),
        .clr_stb    (clr_stb),
        .clr_mask   (clr_mask),
        .en         (en),
        .route_flat (route_flat)
    );

    route_matrix u_matrix (
        .pending    (pending),
        .route_flat (route_flat),
        .en         (en),
        .level      (irq_level)
    );

    assign slot_active = en;

    // R6: an inactive slot never carries a level
    p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level & ~slot_active) == '0);

    // R1: lines above the routable range never receive a source
    p_top_lines_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level[N_LINES-1:N_ROUTABLE] == '0);

    // R5: UART 0, routed to an enabled line, is visible in the same cycle
    p_uart_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_irq[0] && ((route_to_mask(route_flat[5*ROUTE_W +: ROUTE_W]) & slot_active) != '0))
        |-> ((irq_level & route_to_mask(route_flat[5*ROUTE_W +: ROUTE_W])) != '0));

endmodule

// File: tb/test_intr_router.sv
module test_intr_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [2:0]  tmr_evt = '0;
    logic        gpio_evt = 1'b0;
    logic        wdt_evt = 1'b0;
    logic [1:0]  uart_irq = '0;
    logic [1:0]  exp_irq = '0;
    logic [10:0] irq_level;
    logic [10:0] slot_active;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    intr_router i_intr_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .tmr_evt(tmr_evt), .gpio_evt(gpio_evt), .wdt_evt(wdt_evt),
        .uart_irq(uart_irq), .exp_irq(exp_irq), .irq_level(irq_level),
        .slot_active(slot_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        check("R2 slot_active after reset", slot_active, 11'h000);
        check("R6 irq_level after reset", irq_level, 11'h000);
        rd_check("R9 status after reset", 4'h0, 8'h00);
        rd_check("R2 en_lo after reset", 4'h2, 8'h00);
        for (int a = 4; a <= 8; a++) rd_check("R9 route after reset", 4'(a), 8'h00);
    endtask

    task automatic t_enable;
        wr(4'h2, 8'hA5);
        wr(4'h3, 8'hFF);
        check("R2 slot_active mirrors enables", slot_active, 11'h7A5);
        rd_check("R2 en_lo readback", 4'h2, 8'hA5);
        rd_check("R2 en_hi readback", 4'h3, 8'h07);
        wr(4'h2, 8'hFF);
        check("R2 all enabled", slot_active, 11'h7FF);
    endtask

    task automatic t_sticky;
        wr(4'h4, 8'h01);
        @(negedge clk); tmr_evt = 3'b001;
        @(negedge clk); tmr_evt = 3'b000;
        @(negedge clk);
        rd_check("R3 timer0 status set", 4'h0, 8'h01);
        check("R1 code 1 drives IRQ3", irq_level, 11'h001);
        wr(4'h0, 8'h00);
        rd_check("R3 zero write keeps status", 4'h0, 8'h01);
        wr(4'h0, 8'h01);
        rd_check("R3 write one clears", 4'h0, 8'h00);
        check("R6 level low after clear", irq_level, 11'h000);
    endtask

    task automatic t_collision;
        @(negedge clk); wdt_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h0; wr_data = 8'h10;
        @(negedge clk);
        wr_en = 1'b0; wdt_evt = 1'b0;
        rd_check("R4 set wins over clear", 4'h0, 8'h10);
        wr(4'h0, 8'h10);
        rd_check("R3 watchdog cleared", 4'h0, 8'h00);
    endtask

    task automatic t_live;
        wr(4'h6, 8'h50);
        rd_check("R8 route byte 0x6 readback", 4'h6, 8'h50);
        uart_irq = 2'b01;
        #1;
        check("R5 uart0 to IRQ7 same cycle", irq_level, 11'h010);
        rd_check("R5 live read uart0", 4'h1, 8'h01);
        uart_irq = 2'b00;
        #1;
        check("R5 uart0 not latched", irq_level, 11'h000);
        wr(4'h8, 8'hF7);
        rd_check("R8 unused nibble reads 0", 4'h8, 8'h07);
        exp_irq = 2'b10;
        #1;
        check("R5 exp1 code 7 to IRQ10", irq_level, 11'h040);
        rd_check("R5 live read exp1", 4'h1, 8'h08);
        exp_irq = 2'b00;
        rd_check("R8 address above map reads 0", 4'hC, 8'h00);
    endtask

    task automatic t_share;
        wr(4'h4, 8'h81);
        wr(4'h5, 8'h80);
        @(negedge clk); tmr_evt = 3'b010; gpio_evt = 1'b1;
        @(negedge clk); tmr_evt = 3'b000; gpio_evt = 1'b0;
        rd_check("R3 timer1 and gpio set", 4'h0, 8'h0A);
        check("R7 shared IRQ11 high", irq_level, 11'h080);
        wr(4'h0, 8'h02);
        check("R7 line stays high with one left", irq_level, 11'h080);
        wr(4'h2, 8'h7F);
        check("R6 disabled line low", irq_level, 11'h000);
        check("R6 disabled slot inactive", slot_active, 11'h77F);
        rd_check("R6 status kept while disabled", 4'h0, 8'h08);
        wr(4'h2, 8'hFF);
        check("R6 re-enabled line high", irq_level, 11'h080);
        wr(4'h0, 8'h08);
        check("R7 line low after last clear", irq_level, 11'h000);
    endtask

    task automatic t_unassigned;
        wr(4'h7, 8'h90);
        exp_irq = 2'b01;
        #1;
        check("R1 code 9 drives nothing", irq_level, 11'h000);
        rd_check("R5 live read exp0", 4'h1, 8'h04);
        wr(4'h7, 8'h00);
        check("R1 code 0 drives nothing", irq_level, 11'h000);
        wr(4'h7, 8'h80);
        check("R1 code 8 drives IRQ11", irq_level, 11'h080);
        exp_irq = 2'b00;
        #1;
        check("R5 exp0 released", irq_level, 11'h000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_sticky();
        t_collision();
        t_live();
        t_share();
        t_unassigned();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule